// File: doc/BRIEF.md
# Flash Controller Command and Interrupt Status Unit

This block is the register front end that sits between a host bus and the operation engines of a flash memory controller. The host issues commands and configures the interrupt output through a small word-addressed register set. It acknowledges finished work by writing a mask to the interrupt register. The engines that move data, program and erase report back through single-cycle completion pulses, which carry a shared failure flag. The block keeps no array, buffer or ECC state. It only tracks command issue, completion and error flags, and the level interrupt pin.

A command write is taken only while the master interrupt flag is clear. A command that is taken and known is passed on to the engines as a one-cycle issue pulse. An unknown code is turned away at once and flagged as a command error. The interrupt pin is formed from the master flag and a polarity bit in the first configuration word, so the same hardware can serve an active-high or an active-low interrupt line.

Top module: `flash_irq_regs`

## Requirements
- R1: Register offsets on `bus_addr` are 0 command, 1 configuration word 1, 2 controller status, 3 interrupt status and 4 configuration word 2. Offsets 5 to 7 read as 0. Writes to the status register and to offsets 5 to 7 change nothing.
- R2: A read (`bus_valid`=1, `bus_write`=0) returns its data on `bus_rdata` in the cycle after the request. The data is the register value as it stood before any update made in the request cycle.
- R3: A write to the interrupt register replaces it with its bitwise AND with the written word. If bit 15 of that result is 0, status bits 10 to 13 (the error flags) are cleared.
- R4: A command write is discarded while bit 15 of the interrupt register is 1. The command register then keeps its value and no issue pulse follows.
- R5: `irq` equals interrupt bit 15 XOR the inverse of configuration word 1 bit 6. With bit 6 = 1 the pin is active high; with bit 6 = 0 it is active low.
- R6: Cold reset (`rst_n` low) sets interrupt 0x8080, configuration word 1 0x40C0, configuration word 2 0, status 0, command 0 and `ready` 1. A `done_reset` pulse sets the same values, except that the interrupt register becomes 0x8010. `done_reset` overrides any other update in its cycle.
- R7: Reads of configuration word 1 return the stored value ANDed with 0xFFE0. `ready` takes bit 7 of the written word on every write to configuration word 1 and otherwise changes only on reset.
- R8: `done_op` bit 0 is load, bit 1 program and bit 2 erase. A pulse on a bit sets interrupt bit 15 together with the done flag of that operation: load bit 7, program bit 6, erase bit 5. If `op_fail` is 1 in the same cycle, status bit 10 (command error) is also set, together with the error flag of that operation: load bit 13, program bit 12, erase bit 11.
- R9: An accepted command write whose code is not in the known list sets status bit 10 and interrupt bit 15 in the next cycle, and no issue pulse follows.
- R10: The known codes are 16-bit values with the upper byte 0 and a low byte in {0x00, 0x13, 0x80, 0x1A, 0x1B, 0x23, 0x27, 0x2A, 0x2C, 0x71, 0x94, 0x95, 0xB0, 0x30, 0xF0, 0xF3, 0x65}. An accepted known command makes `cmd_valid` high for exactly the next cycle, with `cmd_code` equal to the written word.
- R11: When an interrupt acknowledge and a completion pulse fall in the same cycle, the AND mask and the error clearing are applied first. The completion flags are then ORed in, so a new completion is never lost.
- R12: The command register reads back the last accepted command word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low cold reset, synchronous |
| bus_valid | input | 1 | Host access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the request |
| done_op | input | 3 | Completion pulses: bit 0 load, bit 1 program, bit 2 erase |
| op_fail | input | 1 | Failure flag for the completions of this cycle |
| done_reset | input | 1 | Warm or command reset completion pulse |
| cmd_valid | output | 1 | One-cycle issue pulse for an accepted known command |
| cmd_code | output | 16 | Current command register |
| irq | output | 1 | Interrupt pin with programmable polarity |
| ready | output | 1 | Ready line from configuration word 1 bit 7 |

## Verification
Two functions can meet in one cycle: an interrupt acknowledge from the host and a completion pulse from an engine. The bench drives both on the same clock edge. It does this with and without an error already pending and with the failure flag set. It then reads back the interrupt and status words, expecting the new done and error flags on top of the cleared old ones. A second collision, a command write landing in the same cycle as a completion, is judged by the issue pulse and the command readback. The master flag seen by the command write is its value before that edge.

// File: rtl/fisu_pkg.sv
package fisu_pkg;

    localparam int WORD_W   = 16;
    localparam int SEL_W    = 3;
    localparam int NUM_OPS  = 3;
    localparam int NUM_CODES = 17;

    // interrupt word bit positions
    localparam int MASTER_BIT     = 15;
    localparam int RST_DONE_BIT   = 4;
    localparam int ERASE_DONE_BIT = 5;
    localparam int PROG_DONE_BIT  = 6;
    localparam int LOAD_DONE_BIT  = 7;

    // status word bit positions
    localparam int CMD_ERR_BIT   = 10;
    localparam int ERASE_ERR_BIT = 11;
    localparam int PROG_ERR_BIT  = 12;
    localparam int LOAD_ERR_BIT  = 13;

    // configuration word 1 bit positions
    localparam int POL_BIT = 6;
    localparam int RDY_BIT = 7;

    // operation index on the completion vector
    localparam int OP_LOAD  = 0;
    localparam int OP_PROG  = 1;
    localparam int OP_ERASE = 2;

    localparam logic [WORD_W-1:0] INTR_COLD    = 16'h8080;
    localparam logic [WORD_W-1:0] INTR_WARM    = 16'h8010;
    localparam logic [WORD_W-1:0] CFG1_INIT    = 16'h40C0;
    localparam logic [WORD_W-1:0] CFG1_RD_MASK = 16'hFFE0;
    localparam logic [WORD_W-1:0] ERR_MASK     =
        (WORD_W'(1) << CMD_ERR_BIT) | (WORD_W'(1) << ERASE_ERR_BIT) |
        (WORD_W'(1) << PROG_ERR_BIT) | (WORD_W'(1) << LOAD_ERR_BIT);

    // register selectors
    localparam logic [SEL_W-1:0] SEL_CMD    = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CFG1   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_STATUS = 3'd2;
    localparam logic [SEL_W-1:0] SEL_INTR   = 3'd3;
    localparam logic [SEL_W-1:0] SEL_CFG2   = 3'd4;

    // low bytes of the accepted command codes
    localparam logic [7:0] CODE_LIST [NUM_CODES] = '{
        8'h00, 8'h13, 8'h80, 8'h1A, 8'h1B, 8'h23, 8'h27, 8'h2A, 8'h2C,
        8'h71, 8'h94, 8'h95, 8'hB0, 8'h30, 8'hF0, 8'hF3, 8'h65
    };

    function automatic int done_pos(input int op);
        case (op)
            OP_LOAD:  return LOAD_DONE_BIT;
            OP_PROG:  return PROG_DONE_BIT;
            default:  return ERASE_DONE_BIT;
        endcase
    endfunction

    function automatic int err_pos(input int op);
        case (op)
            OP_LOAD:  return LOAD_ERR_BIT;
            OP_PROG:  return PROG_ERR_BIT;
            default:  return ERASE_ERR_BIT;
        endcase
    endfunction

    typedef struct packed {
        logic [WORD_W-1:0] cmd;
        logic [WORD_W-1:0] cfg1;
        logic [WORD_W-1:0] cfg2;
        logic [WORD_W-1:0] status;
        logic [WORD_W-1:0] intr;
        logic              ready;
        logic              pulse;
    } core_state_t;

endpackage

// File: rtl/fisu_cmd_decode.sv
module fisu_cmd_decode
    import fisu_pkg::*;
(
    input  logic [WORD_W-1:0] code,
    output logic              known
);
    localparam int HI_W = WORD_W - 8;

    logic [NUM_CODES-1:0] hit;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CODES; gi++) begin : g_cmp
            assign hit[gi] = (code[7:0] == CODE_LIST[gi]);
        end
    endgenerate

    assign known = (code[WORD_W-1:8] == HI_W'(0)) && (|hit);
endmodule

// File: rtl/fisu_op_events.sv
module fisu_op_events
    import fisu_pkg::*;
(
    input  logic [NUM_OPS-1:0] done_op,
    input  logic               op_fail,
    output logic [WORD_W-1:0]  intr_set,
    output logic [WORD_W-1:0]  err_set
);
    logic [WORD_W-1:0] op_intr [NUM_OPS];
    logic [WORD_W-1:0] op_err  [NUM_OPS];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_OPS; gi++) begin : g_op
            localparam int DP = done_pos(gi);
            localparam int EP = err_pos(gi);
            assign op_intr[gi] = done_op[gi]
                ? ((WORD_W'(1) << MASTER_BIT) | (WORD_W'(1) << DP))
                : '0;
            assign op_err[gi] = (done_op[gi] && op_fail)
                ? ((WORD_W'(1) << CMD_ERR_BIT) | (WORD_W'(1) << EP))
                : '0;
        end
    endgenerate

    always_comb begin
        intr_set = '0;
        err_set  = '0;
        for (int i = 0; i < NUM_OPS; i++) begin
            intr_set = intr_set | op_intr[i];
            err_set  = err_set | op_err[i];
        end
    end
endmodule

// File: rtl/fisu_status_core.sv
module fisu_status_core
    import fisu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              cmd_known,
    input  logic [NUM_OPS-1:0] done_op,
    input  logic [WORD_W-1:0] intr_set,
    input  logic [WORD_W-1:0] err_set,
    input  logic              done_reset,
    output logic [WORD_W-1:0] cmd_q,
    output logic [WORD_W-1:0] cfg1_q,
    output logic [WORD_W-1:0] cfg2_q,
    output logic [WORD_W-1:0] status_q,
    output logic [WORD_W-1:0] intr_q,
    output logic              ready_q,
    output logic              pulse_q
);
    core_state_t st_d, st_q;

    logic wr_cmd, wr_cfg1, wr_cfg2, wr_intr;

    assign wr_cmd  = wr_en && (wr_sel == SEL_CMD);
    assign wr_cfg1 = wr_en && (wr_sel == SEL_CFG1);
    assign wr_cfg2 = wr_en && (wr_sel == SEL_CFG2);
    assign wr_intr = wr_en && (wr_sel == SEL_INTR);

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;

        // acknowledge first, so that fresh events below survive it
        if (wr_intr) begin
            st_d.intr = st_q.intr & wr_data;
            if (!st_d.intr[MASTER_BIT]) begin
                st_d.status = st_q.status & ~ERR_MASK;
            end
        end

        if (wr_cfg1) begin
            st_d.cfg1  = wr_data;
            st_d.ready = wr_data[RDY_BIT];
        end

        if (wr_cfg2) begin
            st_d.cfg2 = wr_data;
        end

        if (wr_cmd && !st_q.intr[MASTER_BIT]) begin
            st_d.cmd = wr_data;
            if (cmd_known) begin
                st_d.pulse = 1'b1;
            end else begin
                st_d.status[CMD_ERR_BIT] = 1'b1;
                st_d.intr[MASTER_BIT]    = 1'b1;
            end
        end

        st_d.intr   = st_d.intr | intr_set;
        st_d.status = st_d.status | err_set;

        if (done_reset) begin
            st_d.cmd    = '0;
            st_d.cfg1   = CFG1_INIT;
            st_d.cfg2   = '0;
            st_d.status = '0;
            st_d.intr   = INTR_WARM;
            st_d.ready  = 1'b1;
            st_d.pulse  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cmd    <= '0;
            st_q.cfg1   <= CFG1_INIT;
            st_q.cfg2   <= '0;
            st_q.status <= '0;
            st_q.intr   <= INTR_COLD;
            st_q.ready  <= 1'b1;
            st_q.pulse  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_q    = st_q.cmd;
    assign cfg1_q   = st_q.cfg1;
    assign cfg2_q   = st_q.cfg2;
    assign status_q = st_q.status;
    assign intr_q   = st_q.intr;
    assign ready_q  = st_q.ready;
    assign pulse_q  = st_q.pulse;

    // R3
    err_needs_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !intr_q[MASTER_BIT] |-> ((status_q & ERR_MASK) == '0));

    // R4
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && intr_q[MASTER_BIT] && !done_reset) |=> $stable(cmd_q));

    // R8
    done_sets_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|done_op) && !done_reset) |=> intr_q[MASTER_BIT]);

    // R10
    pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> $past(wr_cmd && !intr_q[MASTER_BIT]));
endmodule

// File: rtl/fisu_irq_out.sv
module fisu_irq_out
    import fisu_pkg::*;
(
    input  logic [WORD_W-1:0] intr_q,
    input  logic [WORD_W-1:0] cfg1_q,
    output logic              irq
);
    assign irq = intr_q[MASTER_BIT] ^ ~cfg1_q[POL_BIT];
endmodule

// File: rtl/flash_irq_regs.sv
module flash_irq_regs
    import fisu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [SEL_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_OPS-1:0]  done_op,
    input  logic                op_fail,
    input  logic                done_reset,
    output logic                cmd_valid,
    output logic [WORD_W-1:0]   cmd_code,
    output logic                irq,
    output logic                ready
);
    logic              cmd_known;
    logic [WORD_W-1:0] intr_set, err_set;
    logic [WORD_W-1:0] cmd_q, cfg1_q, cfg2_q, status_q, intr_q;
    logic              wr_en, rd_en;
    logic [WORD_W-1:0] rdata_d, rdata_q;

    assign wr_en = bus_valid && bus_write;
    assign rd_en = bus_valid && !bus_write;

    fisu_cmd_decode u_dec (
        .code  (bus_wdata),
        .known (cmd_known)
    );

    fisu_op_events u_evt (
        .done_op  (done_op),
        .op_fail  (op_fail),
        .intr_set (intr_set),
        .err_set  (err_set)
    );

    fisu_status_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (bus_addr),
        .wr_data    (bus_wdata),
        .cmd_known  (cmd_known),
        .done_op    (done_op),
        .intr_set   (intr_set),
        .err_set    (err_set),
        .done_reset (done_reset),
        .cmd_q      (cmd_q),
        .cfg1_q     (cfg1_q),
        .cfg2_q     (cfg2_q),
        .status_q   (status_q),
        .intr_q     (intr_q),
        .ready_q    (ready),
        .pulse_q    (cmd_valid)
    );

    fisu_irq_out u_irq (
        .intr_q (intr_q),
        .cfg1_q (cfg1_q),
        .irq    (irq)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en) begin
            case (bus_addr)
                SEL_CMD:    rdata_d = cmd_q;
                SEL_CFG1:   rdata_d = cfg1_q & CFG1_RD_MASK;
                SEL_STATUS: rdata_d = status_q;
                SEL_INTR:   rdata_d = intr_q;
                SEL_CFG2:   rdata_d = cfg2_q;
                default:    rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign bus_rdata = rdata_q;
    assign cmd_code  = cmd_q;

    // R7
    ready_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ready) |-> $past((wr_en && bus_addr == SEL_CFG1) || done_reset));

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(bus_rdata));
endmodule

// File: tb/flash_irq_regs_bench.sv
module flash_irq_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  done_op = '0;
    logic        op_fail = 1'b0;
    logic        done_reset = 1'b0;
    logic        cmd_valid;
    logic [15:0] cmd_code;
    logic        irq;
    logic        ready;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    flash_irq_regs u_flash_irq_regs (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .done_op(done_op), .op_fail(op_fail), .done_reset(done_reset),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .irq(irq), .ready(ready)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_done(input logic [2:0] ops, input logic fail);
        @(negedge clk);
        done_op = ops; op_fail = fail;
        @(negedge clk);
        done_op = '0; op_fail = 1'b0;
    endtask

    function automatic bit known(input logic [15:0] c);
        logic [7:0] lo;
        lo = c[7:0];
        if (c[15:8] != 8'h00) return 0;
        return lo == 8'h00 || lo == 8'h13 || lo == 8'h80 || lo == 8'h1A ||
               lo == 8'h1B || lo == 8'h23 || lo == 8'h27 || lo == 8'h2A ||
               lo == 8'h2C || lo == 8'h71 || lo == 8'h94 || lo == 8'h95 ||
               lo == 8'hB0 || lo == 8'h30 || lo == 8'hF0 || lo == 8'hF3 ||
               lo == 8'h65;
    endfunction

    initial begin
        repeat (2000000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] last_cmd;
        logic [15:0] done_b [3];
        logic [15:0] err_b [3];
        done_b[0] = 16'h0080; done_b[1] = 16'h0040; done_b[2] = 16'h0020;
        err_b[0]  = 16'h2000; err_b[1]  = 16'h1000; err_b[2]  = 16'h0800;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6 cold reset values, R1 map, R7 masked read
        rd(3'd3, v); chk("R6 intr cold", v, 16'h8080);
        rd(3'd1, v); chk("R6 cfg1 reset", v, 16'h40C0);
        rd(3'd2, v); chk("R6 status reset", v, 16'h0000);
        rd(3'd4, v); chk("R6 cfg2 reset", v, 16'h0000);
        rd(3'd0, v); chk("R12 cmd reset", v, 16'h0000);
        chk("R5 irq after reset", {15'd0, irq}, 16'd1);
        chk("R6 ready after reset", {15'd0, ready}, 16'd1);

        // R4 command discarded while master set
        wr(3'd0, 16'h0094);
        chk("R4 no issue pulse", {15'd0, cmd_valid}, 16'd0);
        rd(3'd0, v); chk("R4 cmd kept", v, 16'h0000);

        // R3 partial mask then full clear
        wr(3'd3, 16'h7FFF);
        rd(3'd3, v); chk("R3 and mask", v, 16'h0080);
        chk("R5 irq low after ack", {15'd0, irq}, 16'd0);
        wr(3'd3, 16'h0000);
        rd(3'd3, v); chk("R3 cleared", v, 16'h0000);

        // R1 status and unmapped writes ignored, unmapped reads zero
        wr(3'd2, 16'hFFFF);
        rd(3'd2, v); chk("R1 status write ignored", v, 16'h0000);
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 16'hA5A5);
            rd(3'(a), v); chk("R1 unmapped read zero", v, 16'h0000);
        end
        rd(3'd4, v); chk("R1 cfg2 untouched", v, 16'h0000);
        wr(3'd4, 16'h1234);
        rd(3'd4, v); chk("R1 cfg2 write", v, 16'h1234);

        // R8 completion sweep over operations and failure flag
        for (int op = 0; op < 3; op++) begin
            for (int f = 0; f < 2; f++) begin
                pulse_done(3'(1 << op), f[0]);
                chk("R5 irq on completion", {15'd0, irq}, 16'd1);
                rd(3'd3, v); chk("R8 intr flags", v, 16'h8000 | done_b[op]);
                rd(3'd2, v); chk("R8 err flags", v, f ? (16'h0400 | err_b[op]) : 16'h0000);
                wr(3'd3, 16'h8000);
                rd(3'd2, v); chk("R3 errs kept while master", v, f ? (16'h0400 | err_b[op]) : 16'h0000);
                wr(3'd3, 16'h0000);
                rd(3'd2, v); chk("R3 errs cleared", v, 16'h0000);
            end
        end

        // R9 R10 command code sweep, R12 readback
        last_cmd = 16'h0000;
        for (int c = 0; c < 257; c++) begin
            logic [15:0] code;
            code = (c == 256) ? 16'h0100 : 16'(c);
            wr(3'd0, code);
            if (known(code)) begin
                chk("R10 issue pulse", {15'd0, cmd_valid}, 16'd1);
                chk("R10 issue code", cmd_code, code);
                @(negedge clk);
                chk("R10 pulse one cycle", {15'd0, cmd_valid}, 16'd0);
                rd(3'd3, v); chk("R10 no master", v, 16'h0000);
            end else begin
                chk("R9 no pulse", {15'd0, cmd_valid}, 16'd0);
                rd(3'd3, v); chk("R9 master set", v, 16'h8000);
                rd(3'd2, v); chk("R9 cmd err", v, 16'h0400);
                wr(3'd3, 16'h0000);
            end
            rd(3'd0, v); chk("R12 cmd readback", v, code);
        end

        // R5 R7 polarity and ready sweep over cfg1 bits 6 and 7
        for (int p = 0; p < 4; p++) begin
            for (int m = 0; m < 2; m++) begin
                logic [15:0] cw;
                cw = 16'h001F | (p[0] ? 16'h0040 : 16'h0) | (p[1] ? 16'h0080 : 16'h0) | 16'h2300;
                wr(3'd1, cw);
                if (m == 1) pulse_done(3'b001, 1'b0);
                chk("R5 irq polarity", {15'd0, irq}, {15'd0, (m[0] ^ ~p[0])});
                chk("R7 ready follows", {15'd0, ready}, {15'd0, p[1]});
                rd(3'd1, v); chk("R7 cfg1 mask", v, cw & 16'hFFE0);
                wr(3'd3, 16'h0000);
            end
        end

        // R11 acknowledge and completion in one cycle
        pulse_done(3'b100, 1'b1);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 3'd3; bus_wdata = 16'h0000;
        done_op = 3'b010; op_fail = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; done_op = '0; op_fail = 1'b0;
        rd(3'd3, v); chk("R11 intr after collision", v, 16'h8040);
        rd(3'd2, v); chk("R11 status after collision", v, 16'h1400);
        wr(3'd3, 16'h0000);

        // R11 command write alongside completion: master sampled before edge
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 3'd0; bus_wdata = 16'h0080;
        done_op = 3'b001;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; done_op = '0;
        chk("R11 cmd accepted", {15'd0, cmd_valid}, 16'd1);
        rd(3'd3, v); chk("R11 load done", v, 16'h8080);

        // R2 read reflects pre-write state: read issued alone then value
        wr(3'd4, 16'h00AA);
        rd(3'd4, v); chk("R2 read data", v, 16'h00AA);

        // R6 warm reset overrides a simultaneous write
        wr(3'd1, 16'h0000);
        chk("R7 ready low", {15'd0, ready}, 16'd0);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 3'd4; bus_wdata = 16'hFFFF;
        done_reset = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; done_reset = 1'b0;
        chk("R6 ready warm", {15'd0, ready}, 16'd1);
        rd(3'd3, v); chk("R6 intr warm", v, 16'h8010);
        rd(3'd1, v); chk("R6 cfg1 warm", v, 16'h40C0);
        rd(3'd4, v); chk("R6 cfg2 warm", v, 16'h0000);
        rd(3'd2, v); chk("R6 status warm", v, 16'h0000);
        rd(3'd0, v); chk("R6 cmd warm", v, 16'h0000);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule